// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block expands one burst request into the column address for every beat of a memory read or write burst. A request carries a starting column, a length code (2, 4 or 8 beats) and an ordering choice (wrapping count-up or XOR interleave). The block accepts the request on a clock edge. From the next cycle it shows one column per clock, together with a valid flag and a flag on the final beat.

Only the column bits inside the burst window change from beat to beat. The window is 1, 2 or 3 bits wide, set by the length. Every bit above the window is copied from the starting column. While a burst is running, further requests are ignored. A request with the unused length code starts nothing.

Top module: `burst_col_seq`

## Requirements
- R1: `bl_sel_i` is decoded as 2'b01 = 2 beats, 2'b10 = 4 beats and 2'b11 = 8 beats. An accepted burst holds `valid_o` high for exactly that many consecutive cycles, and `last_o` is high only on the final one.
- R2: A request is accepted on a rising edge where `start_i` is high and `valid_o` is low. Beat 0 appears in the cycle that follows that edge, and one further beat follows on each clock.
- R3: With `intlv_i` = 0 (sequential), the window bits of beat n equal (start + n) modulo the burst length. For example, start 2 with 4 beats gives 2,3,0,1, and start 5 with 8 beats gives 5,6,7,0,1,2,3,4.
- R4: With `intlv_i` = 1 (interleave), the window bits of beat n equal start XOR n. For example, start 3 with 8 beats gives 3,2,1,0,7,6,5,4, and start 5 gives 5,4,7,6,1,0,3,2.
- R5: For a 2-beat burst both orderings give the same sequence: 0,1 from an even start and 1,0 from an odd start.
- R6: Column bits above the burst window (bit 1 and up for 2 beats, bit 2 and up for 4, bit 3 and up for 8) equal the starting column on every beat.
- R7: A `start_i` pulse while `valid_o` is high is ignored. The running burst keeps its length, ordering and starting column.
- R8: A request with `bl_sel_i` = 2'b00 starts no burst, so `valid_o` stays low.
- R9: During and after reset `valid_o` and `last_o` are low. `col_o` reads zero whenever `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request |
| start_col_i | input | COL_W | Starting column address |
| bl_sel_i | input | 2 | Burst length code |
| intlv_i | input | 1 | 0 sequential, 1 interleave ordering |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Beat present |
| last_o | output | 1 | Final beat of the burst |

## Verification
A beat counter that drifts shows up within one clock as a wrong window value in `col_o`, and at the end of the burst as a `last_o` that is early, late or missing. A stale or mis-latched length mask corrupts the bits above the window, or changes the burst duration on the first burst that uses it. A restart rule that lets requests through during a burst makes `col_o` jump to another start, or stretches `valid_o`, in the cycle after the stray pulse. Each beat's column, valid and last are therefore compared in the same cycle against a model of the orderings.

// File: rtl/bcas_pkg.sv
package bcas_pkg;
  localparam int unsigned WIN_W = 3;  // widest burst window, 8 beats

  typedef enum logic [1:0] {
    BL_NONE = 2'b00,
    BL_2    = 2'b01,
    BL_4    = 2'b10,
    BL_8    = 2'b11
  } bl_sel_e;

  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_INTLV = 1'b1
  } ord_e;
endpackage

// File: rtl/bcas_len_decode.sv
module bcas_len_decode
  import bcas_pkg::*;
(
  input  logic [1:0]       bl_sel_i,
  output logic             legal_o,
  output logic [WIN_W-1:0] mask_o
);
  always_comb begin
    legal_o = 1'b1;
    unique case (bl_sel_e'(bl_sel_i))
      BL_2:    mask_o = 3'b001;
      BL_4:    mask_o = 3'b011;
      BL_8:    mask_o = 3'b111;
      default: begin
        mask_o  = '0;
        legal_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bcas_beat_ctrl.sv
module bcas_beat_ctrl
  import bcas_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             legal_i,
  input  logic [WIN_W-1:0] mask_i,
  output logic             accept_o,
  output logic             active_o,
  output logic             last_o,
  output logic [WIN_W-1:0] beat_o,
  output logic [WIN_W-1:0] mask_o
);
  logic             active_q;
  logic [WIN_W-1:0] beat_q;
  logic [WIN_W-1:0] mask_q;

  // restart only from idle
  assign accept_o = start_i && legal_i && !active_q;
  assign last_o   = active_q && (beat_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      beat_q   <= '0;
      mask_q   <= '0;
    end else if (accept_o) begin
      active_q <= 1'b1;
      beat_q   <= '0;
      mask_q   <= mask_i;
    end else if (active_q) begin
      if (last_o) begin
        active_q <= 1'b0;
        beat_q   <= '0;
      end else begin
        beat_q <= beat_q + WIN_W'(1);
      end
    end
  end

  assign active_o = active_q;
  assign beat_o   = beat_q;
  assign mask_o   = mask_q;

  AST_LAST_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> active_o);  // R1
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !active_o);  // R1
  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !last_o) |=> (active_o && beat_o == $past(beat_o) + WIN_W'(1)));  // R2
  AST_FIRST_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && legal_i && !active_o) |=> (active_o && beat_o == '0));  // R2
  AST_MASK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !last_o) |=> $stable(mask_o));  // R7
  AST_ILLEGAL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !legal_i) |=> !active_o);  // R8
endmodule

// File: rtl/bcas_addr_gen.sv
module bcas_addr_gen
  import bcas_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             intlv_i,
  input  logic             active_i,
  input  logic [WIN_W-1:0] beat_i,
  input  logic [WIN_W-1:0] mask_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] base_q;
  ord_e             ord_q;
  logic [WIN_W-1:0] ord_lo;
  logic [COL_W-1:0] col_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ord_q  <= ORD_SEQ;
    end else if (accept_i) begin
      base_q <= start_col_i;
      ord_q  <= ord_e'(intlv_i);
    end
  end

  // count-up wraps naturally once masked to the window
  always_comb begin
    if (ord_q == ORD_INTLV) ord_lo = base_q[WIN_W-1:0] ^ beat_i;
    else                    ord_lo = base_q[WIN_W-1:0] + beat_i;
  end

  for (genvar g = 0; g < COL_W; g++) begin : g_bit
    if (g < WIN_W) begin : g_win
      assign col_d[g] = mask_i[g] ? ord_lo[g] : base_q[g];
    end else begin : g_hi
      assign col_d[g] = base_q[g];
    end
  end

  assign col_o = active_i ? col_d : '0;

  AST_UPPER_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i)) |-> (col_o[COL_W-1:WIN_W] == $past(col_o[COL_W-1:WIN_W])));  // R6
  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (col_o == '0));  // R9
  AST_OUTSIDE_MASK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && $past(active_i)) |-> ((col_o[WIN_W-1:0] & ~mask_i) == ($past(col_o[WIN_W-1:0]) & ~mask_i)));  // R6
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcas_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       bl_sel_i,
  input  logic             intlv_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic             legal;
  logic [WIN_W-1:0] mask_dec;
  logic             accept;
  logic             active;
  logic [WIN_W-1:0] beat;
  logic [WIN_W-1:0] mask_q;

  if (COL_W < WIN_W) begin : g_bad_width
    initial $error("COL_W must cover the burst window");
  end

  bcas_len_decode i_len_decode (
    .bl_sel_i (bl_sel_i),
    .legal_o  (legal),
    .mask_o   (mask_dec)
  );

  bcas_beat_ctrl i_beat_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .legal_i  (legal),
    .mask_i   (mask_dec),
    .accept_o (accept),
    .active_o (active),
    .last_o   (last_o),
    .beat_o   (beat),
    .mask_o   (mask_q)
  );

  bcas_addr_gen #(.COL_W(COL_W)) i_addr_gen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .start_col_i (start_col_i),
    .intlv_i     (intlv_i),
    .active_i    (active),
    .beat_i      (beat),
    .mask_i      (mask_q),
    .col_o       (col_o)
  );

  assign valid_o = active;

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |=> (!valid_o && !last_o));  // R9
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> valid_o);  // R7
endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int unsigned COL_W = 10;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [1:0]       bl_sel_i = 2'b00;
  logic             intlv_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int checks = 0;
  int failures = 0;
  bit reported = 0;

  always #5 clk_i = ~clk_i;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk_i, .rst_ni, .start_i, .start_col_i, .bl_sel_i, .intlv_i,
    .col_o, .valid_o, .last_o
  );

  function automatic int beats_of(logic [1:0] sel);
    return (sel == 2'b00) ? 0 : (1 << sel);
  endfunction

  function automatic logic [COL_W-1:0] exp_col(logic [COL_W-1:0] s, int len, bit il, int n);
    logic [COL_W-1:0] m;
    logic [COL_W-1:0] lo;
    m  = COL_W'(len - 1);
    lo = il ? ((s ^ COL_W'(n)) & m) : ((s + COL_W'(n)) & m);
    return (s & ~m) | lo;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  // R1 R2 R3 R4 R5 R6 R7: run one burst, optional stray starts mid-burst
  task automatic burst(logic [COL_W-1:0] s, logic [1:0] sel, bit il, bit stray, string req);
    int len;
    len = beats_of(sel);
    @(negedge clk_i);
    start_i = 1'b1; start_col_i = s; bl_sel_i = sel; intlv_i = il;
    @(negedge clk_i);
    for (int n = 0; n < len; n++) begin
      if (stray) begin
        start_i = 1'b1; start_col_i = COL_W'($urandom); bl_sel_i = 2'(($urandom % 3) + 1);
        intlv_i = 1'($urandom);
      end else begin
        start_i = 1'b0;
      end
      chk({req, " valid"}, 32'(valid_o), 32'd1);
      chk({req, " col"}, 32'(col_o), 32'(exp_col(s, len, il, n)));
      chk({req, " last"}, 32'(last_o), 32'(n == len - 1));
      if (n < len - 1) @(negedge clk_i);
    end
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R1 idle after burst", 32'(valid_o), 32'd0);
    chk("R9 col zero when idle", 32'(col_o), 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #12;
    chk("R9 reset valid", 32'(valid_o), 32'd0);
    chk("R9 reset last", 32'(last_o), 32'd0);
    chk("R9 reset col", 32'(col_o), 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    burst(10'h002, 2'b10, 1'b0, 1'b0, "R3 seq bl4 start2");
    burst(10'h003, 2'b11, 1'b1, 1'b0, "R4 intlv bl8 start3");
    burst(10'h005, 2'b11, 1'b0, 1'b0, "R3 seq bl8 start5");
    burst(10'h005, 2'b11, 1'b1, 1'b0, "R4 intlv bl8 start5");
    burst(10'h000, 2'b01, 1'b0, 1'b0, "R5 bl2 seq start0");
    burst(10'h001, 2'b01, 1'b1, 1'b0, "R5 bl2 intlv start1");
    burst(10'h3FF, 2'b11, 1'b0, 1'b0, "R6 seq upper bits");
    burst(10'h2AE, 2'b10, 1'b1, 1'b1, "R7 stray starts");

    // R8: illegal length code starts nothing
    @(negedge clk_i);
    start_i = 1'b1; start_col_i = 10'h155; bl_sel_i = 2'b00;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R8 illegal no valid", 32'(valid_o), 32'd0);
    @(negedge clk_i);
    chk("R8 illegal still idle", 32'(valid_o), 32'd0);

    for (int i = 0; i < 60; i++) begin
      burst(COL_W'($urandom), 2'(($urandom % 3) + 1), 1'($urandom), 1'($urandom), "R6 random");
    end

    report();
    $finish;
  end
endmodule